// File: doc/BRIEF.md
# Dual Byte-Strobe DRAM Cycle Decoder

This block is the control logic on the device side of an asynchronous DRAM that is 16 bits wide and has a separate column strobe for each byte. The row strobe, the two byte column strobes, the write enable, the output enable, the shared 10-bit address and the write data all pass through a synchronizer clocked by a fast sampling clock. The decoder works on the sampled copies. It merges the two byte strobes into one internal column strobe and sorts each row-strobe cycle into one of three kinds: a normal access (read and/or write), a refresh where a column strobe falls before the row strobe, or a hidden refresh. It latches the multiplexed row and column addresses. Each byte lane gets its own write strobe and output enable.

The memory array is a small register-file stub. Only the low bits of the row and column select a word in it. Every row-strobe cycle refreshes one row. The decoder reports this on a one-cycle refresh pulse, together with the number of the row that was refreshed. A test environment can use these to confirm that every row is refreshed.

Top module: `dcas_ctrl`

## Requirements
- R1: While reset is held and directly after it, both lane output enables and the refresh pulse are 0, and the internal refresh counter is 0.
- R2: In any normal row-strobe cycle, the row address is latched when the row strobe falls. The same fall produces exactly one refresh pulse, one clock wide, with refresh_row equal to that row address.
- R3: The combined column strobe becomes active when the first byte strobe falls, and the column address is latched at that moment. The combined strobe stays active until the last byte strobe rises. Releasing and lowering one lane while the other stays low does not latch a new column.
- R4: Each byte strobe gates its own lane. lcas_n controls bits 7:0 and output-enable bit 0. ucas_n controls bits 15:8 and output-enable bit 1. A lane whose strobe is high is neither written nor driven.
- R5: A write happens once per active column strobe, when both the column strobe and write enable are low, whichever fell later. The data word is taken as it stands at that moment.
- R6: A read drives the lanes whose strobe is low, but only while write enable is high and output enable is low. It returns the word stored at index {row[2:0], col[2:0]}. The stub resets to all zeros. If output enable is high, no lane is driven.
- R7: If either byte strobe is already low when the row strobe falls, the cycle is a refresh. The refresh row comes from the internal counter, and the address, write enable and data inputs are ignored. No lane is driven and nothing is written.
- R8: The refresh counter goes up by one after each refresh cycle of this kind, and wraps from 1023 to 0.
- R9: A cycle ends only when the row strobe and both byte strobes are high. Both output enables are then 0. If the row strobe rises while a byte strobe is still low, the lanes are released. If the row strobe then falls again, the result is a counter-driven refresh (hidden refresh).
- R10: While the row strobe is low, the combined column strobe can rise and fall again (fast page). Each new fall latches a new column and allows one more write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower byte column strobe, active low |
| ucas_n | input | 1 | Upper byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 10 | Multiplexed row/column address |
| dq_in | input | 16 | Write data |
| dq_out | output | 16 | Read data; an undriven lane shows 0 |
| dq_oe | output | 2 | Per-lane output enable (bit 0 lower, bit 1 upper) |
| refresh_pulse | output | 1 | One-cycle pulse for each refreshed row |
| refresh_row | output | 10 | Row refreshed, valid with refresh_pulse |

## Verification
A wrong state encoding or a stale column-valid flag shows up as lanes being driven in a refresh cycle or after release, or as a write landing at the wrong index. The lane enables are registered, so this is visible at dq_oe three clocks after the strobe edge. A slip in the refresh counter shows on refresh_row at the next counter-driven refresh. A lost or doubled write only shows up later, when a read-back returns the wrong word. For that reason, the random writes are all read back against a model memory.

// File: rtl/dcas_pkg.sv
package dcas_pkg;
    localparam int LANES  = 2;
    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ROW  = 2'd1,
        ST_CBR  = 2'd2,
        ST_PRE  = 2'd3
    } dcas_st_e;
endpackage

// File: rtl/dcas_sync.sv
module dcas_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rst_val,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= rst_val;
                else        chain_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= rst_val;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/dcas_array.sv
module dcas_array
    import dcas_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        wr_be,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [LANES*LANE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [LANES*LANE_W-1:0] mem_q [DEPTH];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) mem_q[i][l*LANE_W +: LANE_W] <= '0;
            end else if (wr_be[l]) begin
                mem_q[wr_idx][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
            end
        end
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/dcas_ctrl.sv
module dcas_ctrl
    import dcas_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int ROW_IDX_W   = 3,
    parameter int COL_IDX_W   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ras_n,
    input  logic                    lcas_n,
    input  logic                    ucas_n,
    input  logic                    we_n,
    input  logic                    oe_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic [LANES-1:0]        dq_oe,
    output logic                    refresh_pulse,
    output logic [ADDR_W-1:0]       refresh_row
);
    localparam int DW    = LANES * LANE_W;
    localparam int IDX_W = ROW_IDX_W + COL_IDX_W;
    localparam int CTL_W = 3 + LANES;
    localparam int IN_W  = CTL_W + ADDR_W + DW;

    typedef struct packed {
        dcas_st_e          st;
        logic [ADDR_W-1:0] row;
        logic [ADDR_W-1:0] col;
        logic              col_ok;
        logic              wr_done;
        logic [ADDR_W-1:0] cnt;
        logic              rf_pulse;
        logic [ADDR_W-1:0] rf_row;
        logic [LANES-1:0]  lane_oe;
        logic [LANES-1:0]  wr_be;
        logic [IDX_W-1:0]  wr_idx;
        logic [DW-1:0]     wr_data;
    } regs_t;

    // synchronized inputs
    logic [IN_W-1:0]   raw_in, sync_in, sync_rst;
    logic              s_ras, s_we, s_oe;
    logic [LANES-1:0]  s_cas;
    logic [ADDR_W-1:0] s_addr;
    logic [DW-1:0]     s_dq;

    assign raw_in   = {ras_n, we_n, oe_n, ucas_n, lcas_n, addr, dq_in};
    assign sync_rst = {{CTL_W{1'b1}}, {(ADDR_W + DW){1'b0}}};

    dcas_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_val (sync_rst),
        .d       (raw_in),
        .q       (sync_in)
    );

    assign {s_ras, s_we, s_oe, s_cas, s_addr, s_dq} = sync_in;

    regs_t            r_d, r_q;
    logic [LANES-1:0] cas_act;
    logic             cas_any;

    assign cas_act = ~s_cas;
    assign cas_any = |cas_act;

    always_comb begin
        r_d          = r_q;
        r_d.rf_pulse = 1'b0;
        r_d.wr_be    = '0;
        unique case (r_q.st)
            ST_IDLE, ST_PRE: begin
                if (!s_ras) begin
                    if (cas_any) begin
                        r_d.st     = ST_CBR;
                        r_d.rf_pulse = 1'b1;
                        r_d.rf_row = r_q.cnt;
                        r_d.cnt    = r_q.cnt + 1'b1;
                    end else begin
                        r_d.st      = ST_ROW;
                        r_d.row     = s_addr;
                        r_d.rf_pulse = 1'b1;
                        r_d.rf_row  = s_addr;
                        r_d.col_ok  = 1'b0;
                        r_d.wr_done = 1'b0;
                    end
                end else if (!cas_any) begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_ROW: begin
                if (s_ras) begin
                    r_d.st     = cas_any ? ST_PRE : ST_IDLE;
                    r_d.col_ok = 1'b0;
                end else begin
                    if (!cas_any) begin
                        r_d.col_ok  = 1'b0;
                        r_d.wr_done = 1'b0;
                    end else if (!r_q.col_ok) begin
                        r_d.col_ok = 1'b1;
                        r_d.col    = s_addr;
                    end
                    if (cas_any && !s_we && !r_q.wr_done) begin
                        r_d.wr_done = 1'b1;
                        r_d.wr_be   = cas_act;
                        r_d.wr_data = s_dq;
                        r_d.wr_idx  = {r_d.row[ROW_IDX_W-1:0], r_d.col[COL_IDX_W-1:0]};
                    end
                end
            end
            ST_CBR: begin
                if (s_ras) r_d.st = cas_any ? ST_PRE : ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
        r_d.lane_oe = (r_d.st == ST_ROW && r_d.col_ok && s_we && !s_oe) ? cas_act : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    logic [DW-1:0] rd_data;

    dcas_array #(.IDX_W(IDX_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_be   (r_q.wr_be),
        .wr_idx  (r_q.wr_idx),
        .wr_data (r_q.wr_data),
        .rd_idx  ({r_q.row[ROW_IDX_W-1:0], r_q.col[COL_IDX_W-1:0]}),
        .rd_data (rd_data)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_out
        assign dq_out[l*LANE_W +: LANE_W] = r_q.lane_oe[l] ? rd_data[l*LANE_W +: LANE_W] : '0;
    end

    assign dq_oe         = r_q.lane_oe;
    assign refresh_pulse = r_q.rf_pulse;
    assign refresh_row   = r_q.rf_row;

    assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.rf_pulse |=> !r_q.rf_pulse);
    assert_one_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|r_q.wr_be) |=> (r_q.wr_be == '0));
    assert_refresh_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CBR) |-> (dq_oe == '0 && r_q.wr_be == '0));
    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CBR && r_q.rf_pulse) |-> (r_q.cnt == r_q.rf_row + 1'b1));
    assert_idle_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_ROW) |-> (dq_oe == '0));
    assert_lane_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe & ~$past(cas_act)) == '0);
endmodule

// File: tb/dcas_ctrl_tb.sv
module dcas_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ras_n, lcas_n, ucas_n, we_n, oe_n;
    logic [9:0]  addr;
    logic [15:0] dq_in;
    logic [15:0] dq_out;
    logic [1:0]  dq_oe;
    logic        refresh_pulse;
    logic [9:0]  refresh_row;

    int total = 0;
    int bad   = 0;
    int pulse_cnt = 0;
    logic [9:0]  last_row = '0;
    logic [9:0]  exp_cnt  = '0;
    logic [15:0] exp_mem [64];

    always #5 clk = ~clk;

    dcas_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe), .refresh_pulse(refresh_pulse), .refresh_row(refresh_row)
    );

    always @(negedge clk) begin
        if (refresh_pulse) begin
            pulse_cnt <= pulse_cnt + 1;
            last_row  <= refresh_row;
        end
    end

    function automatic int idx(input logic [9:0] r, input logic [9:0] c);
        return {26'd0, r[2:0], c[2:0]};
    endfunction

    function automatic logic [15:0] lane_mask(input logic [1:0] ln);
        return {{8{ln[1]}}, {8{ln[0]}}};
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic release_all();
        ras_n = 1'b1; lcas_n = 1'b1; ucas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        step(4);
        chk(dq_oe == 2'b00, "R9 lanes released", {30'd0, dq_oe}, 0);
    endtask

    task automatic open_row(input logic [9:0] r);
        int pc;
        pc = pulse_cnt;
        addr = r; ras_n = 1'b0;
        step(4);
        chk(pulse_cnt == pc + 1 && last_row == r, "R2 row refresh", {22'd0, last_row}, {22'd0, r});
    endtask

    task automatic wr(input logic [9:0] r, input logic [9:0] c, input logic [15:0] d,
                      input logic [1:0] ln, input bit late);
        int i;
        open_row(r);
        addr = c;
        if (late) dq_in = ~d;
        else begin dq_in = d; we_n = 1'b0; end
        lcas_n = ~ln[0]; ucas_n = ~ln[1];
        step(4);
        if (late) begin
            dq_in = d; we_n = 1'b0;
            step(4);
        end
        release_all();
        i = idx(r, c);
        exp_mem[i] = (exp_mem[i] & ~lane_mask(ln)) | (d & lane_mask(ln));
    endtask

    task automatic rd(input logic [9:0] r, input logic [9:0] c, input logic [1:0] ln, input bit oe);
        logic [15:0] e;
        logic [1:0]  eoe;
        open_row(r);
        addr = c; oe_n = ~oe;
        lcas_n = ~ln[0]; ucas_n = ~ln[1];
        step(4);
        eoe = oe ? ln : 2'b00;
        e   = exp_mem[idx(r, c)] & lane_mask(eoe);
        chk(dq_oe == eoe, oe ? "R4 lane enables" : "R6 output enable high", {30'd0, dq_oe}, {30'd0, eoe});
        chk(dq_out == e, "R6 read data", {16'd0, dq_out}, {16'd0, e});
        release_all();
    endtask

    task automatic cbr(input logic [9:0] junk);
        int pc;
        lcas_n = 1'b0;
        step(4);
        pc = pulse_cnt;
        addr = junk; dq_in = {junk[5:0], junk}; we_n = 1'b0; oe_n = 1'b0; ras_n = 1'b0;
        step(4);
        chk(pulse_cnt == pc + 1 && last_row == exp_cnt, "R8 counter row", {22'd0, last_row}, {22'd0, exp_cnt});
        chk(dq_oe == 2'b00, "R7 refresh lanes idle", {30'd0, dq_oe}, 0);
        release_all();
        exp_cnt = exp_cnt + 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [9:0]  r, c;
        logic [15:0] d;
        logic [9:0]  wr_r [40];
        logic [9:0]  wr_c [40];
        void'($urandom(32'd20250));
        for (int i = 0; i < 64; i++) exp_mem[i] = '0;
        rst_n = 1'b0; ras_n = 1'b1; lcas_n = 1'b1; ucas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        addr = '0; dq_in = '0;
        step(3);
        chk(dq_oe == 2'b00 && refresh_pulse == 1'b0, "R1 in reset", {30'd0, dq_oe}, 0);
        rst_n = 1'b1;
        step(4);
        chk(dq_oe == 2'b00 && refresh_pulse == 1'b0, "R1 after reset", {30'd0, dq_oe}, 0);

        // R1: first counter refresh uses row 0
        cbr(10'h3ff);

        // R5 early and late write, R4 single lanes, R6 read back
        wr(10'h011, 10'h002, 16'hA5C3, 2'b11, 1'b0);
        rd(10'h011, 10'h002, 2'b11, 1'b1);
        wr(10'h011, 10'h002, 16'h1234, 2'b01, 1'b1);
        rd(10'h011, 10'h002, 2'b11, 1'b1);
        wr(10'h011, 10'h002, 16'hBEEF, 2'b10, 1'b0);
        rd(10'h011, 10'h002, 2'b10, 1'b1);
        rd(10'h011, 10'h002, 2'b01, 1'b1);
        rd(10'h011, 10'h002, 2'b11, 1'b0);

        // R3 staggered byte strobes: column stays on the first fall
        open_row(10'h005);
        addr = 10'h001; lcas_n = 1'b0; step(4);
        addr = 10'h006; ucas_n = 1'b0; step(4);
        lcas_n = 1'b1; step(4);
        lcas_n = 1'b0; step(4);
        dq_in = 16'h7E81; we_n = 1'b0; step(4);
        release_all();
        exp_mem[idx(10'h005, 10'h001)] = 16'h7E81;
        rd(10'h005, 10'h001, 2'b11, 1'b1);
        chk(dq_out == 16'h0000, "R3 after cycle", {16'd0, dq_out}, 0);
        rd(10'h005, 10'h006, 2'b11, 1'b1);

        // R10 fast page: two columns in one row cycle
        open_row(10'h003);
        addr = 10'h004; dq_in = 16'h1111; we_n = 1'b0; lcas_n = 1'b0; ucas_n = 1'b0; step(4);
        lcas_n = 1'b1; ucas_n = 1'b1; we_n = 1'b1; step(4);
        addr = 10'h007; dq_in = 16'h2222; we_n = 1'b0; lcas_n = 1'b0; ucas_n = 1'b0; step(4);
        release_all();
        exp_mem[idx(10'h003, 10'h004)] = 16'h1111;
        exp_mem[idx(10'h003, 10'h007)] = 16'h2222;
        rd(10'h003, 10'h004, 2'b11, 1'b1);
        rd(10'h003, 10'h007, 2'b11, 1'b1);

        // R9 hidden refresh after a read
        open_row(10'h011);
        addr = 10'h002; lcas_n = 1'b0; oe_n = 1'b0; step(4);
        chk(dq_oe == 2'b01, "R6 hidden read lane", {30'd0, dq_oe}, 1);
        ras_n = 1'b1; step(4);
        chk(dq_oe == 2'b00, "R9 row high lanes off", {30'd0, dq_oe}, 0);
        begin
            int pc;
            pc = pulse_cnt;
            ras_n = 1'b0; we_n = 1'b0; step(4);
            chk(pulse_cnt == pc + 1 && last_row == exp_cnt, "R9 hidden refresh row",
                {22'd0, last_row}, {22'd0, exp_cnt});
            chk(dq_oe == 2'b00, "R7 hidden refresh quiet", {30'd0, dq_oe}, 0);
        end
        release_all();
        exp_cnt = exp_cnt + 1'b1;
        rd(10'h011, 10'h002, 2'b11, 1'b1);

        // random writes and read-back
        for (int i = 0; i < 40; i++) begin
            r = 10'($urandom); c = 10'($urandom); d = 16'($urandom);
            wr_r[i] = r; wr_c[i] = c;
            wr(r, c, d, 2'($urandom_range(1, 3)), 1'($urandom));
        end
        for (int i = 0; i < 40; i++) rd(wr_r[i], wr_c[i], 2'($urandom_range(1, 3)), 1'b1);

        // R7 ignored inputs: data still intact after refresh cycles
        for (int i = 0; i < 8; i++) cbr(10'($urandom));
        rd(10'h011, 10'h002, 2'b11, 1'b1);

        // R8 counter wrap from 1023 to 0
        while (exp_cnt != 10'd1020) cbr(10'($urandom));
        for (int i = 0; i < 6; i++) cbr(10'($urandom));
        chk(last_row == 10'd1, "R8 wrap", {22'd0, last_row}, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule